// File: doc/BRIEF.md
# Two-Phase Pulse Generator

This block produces a pulse train from a 16-bit down counter. Each period has two phases. First comes a LOW phase, timed from a LOW-width register. Then comes a HIGH phase, timed from a HIGH-width register. Each phase ends when the counter passes through zero, so a reload value of N gives a phase of N+1 count clocks.

The count clock can come from an internal divider of the system clock, or from edges on an external clock pin. A period can be started by a software command or by a chosen edge on an external trigger pin. The generator can stop after one period or repeat until it is told to stop. Two interrupt flags, one for trigger and one for underflow, each have an enable, and a polarity bit can invert the pin.

Software reaches the block through a small write port with a 2-bit address:
- Address 0 holds the LOW width.
- Address 1 holds the buffered HIGH width.
- Address 2 holds the control register.
- Address 3 takes commands.

The control register fields are:
- [3:0] count-clock select.
- [5:4] trigger-edge select.
- [6] one-shot.
- [7] invert.
- [8] trigger interrupt enable.
- [9] underflow interrupt enable.

The command bits are:
- bit 0: start.
- bit 1: clear the trigger flag.
- bit 2: clear the underflow flag.
- bit 3: stop.

Top module: `ppg_pulse_gen`

## Requirements
- R1: After reset the pin is at its idle level, which is LOW before inversion, and both interrupt outputs are 0.
- R2: A start event loads the LOW width L and drives the pin LOW. The pin goes HIGH after L+1 count clocks. If the start is applied at clock edge E with divide-by-D, the pin goes HIGH after edge E+(L+1)*D.
- R3: At the underflow that ends the LOW phase, the counter reloads the active HIGH width H. The pin returns LOW H+1 count clocks later.
- R4: In one-shot mode (control bit 6 = 1) the generator stops after the HIGH phase ends and the pin stays at its idle level.
- R5: In continuous mode (bit 6 = 0) the LOW/HIGH sequence repeats. A stop command (command bit 3) halts it and the pin returns to idle.
- R6: A write to the HIGH-width register is copied to the active HIGH width only at the start of a LOW phase, so a write made during a period takes effect in the next period.
- R7: Select codes 0 to 7 divide the system clock by 1, 4, 16, 128, 256, 512, 1024 and 2048. The divider restarts on every start event.
- R8: Select codes 8, 9 and 10 count rising, falling, or both edges of the external clock pin.
- R9: Besides command bit 0, a start comes from the external trigger pin. Trigger-edge codes are 1 for rising, 2 for falling, 3 for both and 0 for none. An edge that is not selected is ignored.
- R10: Every start event sets the trigger flag. The trigger interrupt output equals the flag AND enable bit 8. Command bit 1 clears the flag.
- R11: Every underflow sets the underflow flag. The underflow interrupt output equals the flag AND enable bit 9. Command bit 2 clears the flag, and a set in the same cycle wins over a clear.
- R12: Control bit 7 inverts the pin in every state, idle included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 LOW width, 1 HIGH width, 2 control, 3 command) |
| wr_data | input | 16 | Write data |
| ext_clk | input | 1 | External count clock, synchronous to clk |
| ext_trig | input | 1 | External start trigger, synchronous to clk |
| pulse_out | output | 1 | Pulse pin |
| trig_irq | output | 1 | Trigger interrupt request |
| uf_irq | output | 1 | Underflow interrupt request |

## Verification
The bench predicts the exact cycle of every pin edge for widths of 0 and above, under several dividers. A design off by one count clock per phase, or one that fails to restart its divider at start, lands an edge in the wrong cycle.

A HIGH-width write made during a continuous period must change only the following period. A design that loads the buffer at once, or never loads it, shows a wrong HIGH length. The bench also checks that a stop issued between periods leaves the pin quiet, and that a rising trigger edge is ignored when falling is selected; a design that starts anyway raises the trigger flag.

External counting is checked for all three edge choices, and interrupt gating with the underflow enable off. A design that counts the wrong edge reaches HIGH late or early.

// File: rtl/ppg_pkg.sv
// Package: shared types and constants for the two-phase pulse generator.
// Assumes a 2-bit register address and a 16-bit data path for writes.
package ppg_pkg;
    localparam int CNT_W = 16;
    localparam int DIV_W = 11;

    localparam logic [1:0] A_LOW  = 2'd0;
    localparam logic [1:0] A_HIGH = 2'd1;
    localparam logic [1:0] A_CTRL = 2'd2;
    localparam logic [1:0] A_CMD  = 2'd3;

    typedef struct packed {
        logic       uf_ie;
        logic       trig_ie;
        logic       out_inv;
        logic       one_shot;
        logic [1:0] trig_edge;
        logic [3:0] clk_sel;
    } ctrl_t;

    // Log2 of the internal division ratio for select codes 0..7.
    function automatic logic [3:0] div_shift(input logic [2:0] sel);
        case (sel)
            3'd0: div_shift = 4'd0;
            3'd1: div_shift = 4'd2;
            3'd2: div_shift = 4'd4;
            default: div_shift = 4'(sel) + 4'd4;
        endcase
    endfunction
endpackage

// File: rtl/ppg_edge_det.sv
// Edge detector: flags selected rising and/or falling edges of a
// signal that is already synchronous to clk. One cycle of latency is
// spent on the history register only; the pulse is combinational.
module ppg_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    input  logic en_rise,
    input  logic en_fall,
    output logic hit
);
    logic prev;

    // Remember the previous sample of the input.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= sig;
    end

    // Report only the edges that are enabled.
    always_comb hit = (en_rise & sig & ~prev) | (en_fall & ~sig & prev);
endmodule

// File: rtl/ppg_prescaler.sv
// Count-clock source: a free-running divider that restarts on a start
// event, or an external edge pulse. Assumes select codes above 10 give
// no tick at all.
module ppg_prescaler
    import ppg_pkg::*;
#(
    parameter int DW = DIV_W
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic [3:0] sel,
    input  logic       ext_tick,
    output logic       tick
);
    logic [DW-1:0] div_cnt;
    logic [DW-1:0] mask;

    // Divider counter, zeroed by every start event.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) div_cnt <= '0;
        else                   div_cnt <= div_cnt + 1'b1;
    end

    // Choose the internal tap or the external edge as the count clock.
    always_comb begin
        mask = DW'((1 << div_shift(sel[2:0])) - 1);
        if (!sel[3])          tick = ((div_cnt & mask) == mask);
        else if (sel <= 4'd10) tick = ext_tick;
        else                  tick = 1'b0;
    end
endmodule

// File: rtl/ppg_core.sv
// Phase engine: a down counter that runs a LOW phase from low_w and a
// HIGH phase from the HIGH width held when the period began. A start
// overrides everything; a stop overrides counting.
module ppg_core
    import ppg_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         start,
    input  logic         stop,
    input  logic         one_shot,
    input  logic [W-1:0] low_w,
    input  logic [W-1:0] high_buf,
    output logic         busy,
    output logic         phase_hi,
    output logic         uf_evt
);
    logic [W-1:0] cnt;
    logic [W-1:0] high_act;

    // An underflow is a count tick that finds the counter at zero.
    always_comb uf_evt = busy & tick & (cnt == '0) & ~start & ~stop;

    // Counter, phase and active HIGH width sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            high_act <= '0;
            busy     <= 1'b0;
            phase_hi <= 1'b0;
        end else if (start) begin
            cnt      <= low_w;
            high_act <= high_buf;
            busy     <= 1'b1;
            phase_hi <= 1'b0;
        end else if (stop) begin
            busy     <= 1'b0;
            phase_hi <= 1'b0;
        end else if (busy && tick) begin
            if (cnt != '0) begin
                cnt <= cnt - 1'b1;
            end else if (!phase_hi) begin
                phase_hi <= 1'b1;
                cnt      <= high_act;
            end else if (one_shot) begin
                busy     <= 1'b0;
                phase_hi <= 1'b0;
            end else begin
                phase_hi <= 1'b0;
                cnt      <= low_w;
                high_act <= high_buf;
            end
        end
    end
endmodule

// File: rtl/ppg_pulse_gen.sv
// Top: register file, start/stop decode, interrupt flags and pin
// polarity around the prescaler and phase engine. Assumes ext_clk and
// ext_trig are already synchronous to clk.
module ppg_pulse_gen
    import ppg_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    input  logic         ext_clk,
    input  logic         ext_trig,
    output logic         pulse_out,
    output logic         trig_irq,
    output logic         uf_irq
);
    localparam int CTRL_W = $bits(ctrl_t);

    ctrl_t        ctrl;
    logic [W-1:0] low_w;
    logic [W-1:0] high_buf;
    logic         trig_flag;
    logic         uf_flag;
    logic         cmd_wr;
    logic         sw_start;
    logic         stop_cmd;
    logic         trig_hit;
    logic         clk_hit;
    logic         start_evt;
    logic         tick;
    logic         busy;
    logic         phase_hi;
    logic         uf_evt;

    // Decode command strobes.
    always_comb begin
        cmd_wr    = wr_en && (wr_addr == A_CMD);
        sw_start  = cmd_wr && wr_data[0];
        stop_cmd  = cmd_wr && wr_data[3];
        start_evt = sw_start | trig_hit;
    end

    // Width and control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_w    <= '0;
            high_buf <= '0;
            ctrl     <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_LOW:   low_w    <= wr_data;
                A_HIGH:  high_buf <= wr_data;
                A_CTRL:  ctrl     <= ctrl_t'(wr_data[CTRL_W-1:0]);
                default: ;
            endcase
        end
    end

    // Interrupt flags: a set wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_flag <= 1'b0;
            uf_flag   <= 1'b0;
        end else begin
            if (start_evt)                 trig_flag <= 1'b1;
            else if (cmd_wr && wr_data[1]) trig_flag <= 1'b0;
            if (uf_evt)                    uf_flag   <= 1'b1;
            else if (cmd_wr && wr_data[2]) uf_flag   <= 1'b0;
        end
    end

    ppg_edge_det i_trig_det (
        .clk     (clk),
        .rst_n   (rst_n),
        .sig     (ext_trig),
        .en_rise (ctrl.trig_edge[0]),
        .en_fall (ctrl.trig_edge[1]),
        .hit     (trig_hit)
    );

    ppg_edge_det i_clk_det (
        .clk     (clk),
        .rst_n   (rst_n),
        .sig     (ext_clk),
        .en_rise (ctrl.clk_sel == 4'd8 || ctrl.clk_sel == 4'd10),
        .en_fall (ctrl.clk_sel == 4'd9 || ctrl.clk_sel == 4'd10),
        .hit     (clk_hit)
    );

    ppg_prescaler i_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (start_evt),
        .sel      (ctrl.clk_sel),
        .ext_tick (clk_hit),
        .tick     (tick)
    );

    ppg_core #(.W(W)) i_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .start    (start_evt),
        .stop     (stop_cmd),
        .one_shot (ctrl.one_shot),
        .low_w    (low_w),
        .high_buf (high_buf),
        .busy     (busy),
        .phase_hi (phase_hi),
        .uf_evt   (uf_evt)
    );

    // Pin polarity and interrupt gating.
    always_comb begin
        pulse_out = (busy & phase_hi) ^ ctrl.out_inv;
        trig_irq  = trig_flag & ctrl.trig_ie;
        uf_irq    = uf_flag & ctrl.uf_ie;
    end
endmodule

// File: rtl/ppg_checks.sv
// Checker: temporal properties of the pulse generator, bound to the top.
// Assumes the internal names of ppg_pulse_gen listed in the bind below.
module ppg_checks (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic phase_hi,
    input logic uf_evt,
    input logic one_shot,
    input logic out_inv,
    input logic pulse_out,
    input logic trig_flag,
    input logic uf_flag
);
    // R1, R12: an idle pin sits at the polarity level.
    p_idle_level_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (pulse_out == out_inv));

    // R2: a start opens a LOW phase.
    p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (busy && !phase_hi));

    // R3: the underflow ending LOW enters HIGH.
    p_low_to_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (uf_evt && !phase_hi) |=> phase_hi);

    // R4: one-shot halts after the HIGH phase.
    p_oneshot_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (uf_evt && phase_hi && one_shot) |=> !busy);

    // R10: every start sets the trigger flag.
    p_trig_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> trig_flag);

    // R11: every underflow sets the underflow flag.
    p_uf_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        uf_evt |=> uf_flag);
endmodule

bind ppg_pulse_gen ppg_checks i_ppg_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_evt),
    .busy      (busy),
    .phase_hi  (phase_hi),
    .uf_evt    (uf_evt),
    .one_shot  (ctrl.one_shot),
    .out_inv   (ctrl.out_inv),
    .pulse_out (pulse_out),
    .trig_flag (trig_flag),
    .uf_flag   (uf_flag)
);

// File: tb/test_ppg_pulse_gen.sv
// Scoreboard bench: driver tasks queue the expected pin edges (cycle and
// level); a monitor pops and compares them on every observed change.
module test_ppg_pulse_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        ext_clk = 1'b0;
    logic        ext_trig = 1'b0;
    logic        pulse_out, trig_irq, uf_irq;

    int unsigned cyc = 0;
    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    bit          mon_en = 1'b0;
    logic        prev_out = 1'b0;
    bit          done = 1'b0;

    typedef struct { int unsigned at; logic lvl; string req; } exp_t;
    exp_t q[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ppg_pulse_gen i_ppg_pulse_gen (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ext_clk(ext_clk), .ext_trig(ext_trig),
        .pulse_out(pulse_out), .trig_irq(trig_irq), .uf_irq(uf_irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp_v);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp_v, cyc);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic push(input int unsigned at, input logic lvl, input string req);
        exp_t e;
        e.at = at; e.lvl = lvl; e.req = req;
        q.push_back(e);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ext_pulse();
        @(negedge clk); ext_clk = 1'b1;
        @(negedge clk); ext_clk = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // Monitor: every pin change must match the head of the queue.
    always @(negedge clk) begin
        if (mon_en && rst_n && pulse_out !== prev_out) begin
            if (q.size() == 0) begin
                check(1'b0, "R4/R5 unexpected edge", int'(pulse_out), int'(prev_out));
            end else begin
                exp_t e;
                e = q.pop_front();
                check(cyc == e.at, {e.req, " edge cycle"}, int'(cyc), int'(e.at));
                check(pulse_out == e.lvl, {e.req, " edge level"}, int'(pulse_out), int'(e.lvl));
            end
        end
        prev_out = pulse_out;
    end

    initial begin
        #(8 * 150000);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        int unsigned s;
        idle(3);
        rst_n = 1'b1;
        idle(2);
        // R1: reset state
        check(pulse_out == 1'b0, "R1 pin", int'(pulse_out), 0);
        check(trig_irq == 1'b0, "R1 trig_irq", int'(trig_irq), 0);
        check(uf_irq == 1'b0, "R1 uf_irq", int'(uf_irq), 0);
        mon_en = 1'b1;

        // R2 R3 R4: one-shot, divide by 1, L=3 H=2
        wr(2'd2, 16'h0340);
        wr(2'd0, 16'd3);
        wr(2'd1, 16'd2);
        wr(2'd3, 16'h0001);
        s = cyc;
        check(trig_irq == 1'b1, "R10 trig flag on start", int'(trig_irq), 1);
        check(pulse_out == 1'b0, "R2 low after start", int'(pulse_out), 0);
        check(uf_irq == 1'b0, "R11 no underflow yet", int'(uf_irq), 0);
        push(s + 4, 1'b1, "R2");
        push(s + 7, 1'b0, "R3");
        wait (q.size() == 0);
        check(uf_irq == 1'b1, "R11 underflow flag", int'(uf_irq), 1);
        idle(20);
        check(pulse_out == 1'b0, "R4 stopped after one period", int'(pulse_out), 0);
        wr(2'd3, 16'h0006);
        idle(1);
        check(trig_irq == 1'b0, "R10 trig clear", int'(trig_irq), 0);
        check(uf_irq == 1'b0, "R11 uf clear", int'(uf_irq), 0);

        // R7: divide by 4, L=1 H=0
        wr(2'd2, 16'h0341);
        wr(2'd0, 16'd1);
        wr(2'd1, 16'd0);
        wr(2'd3, 16'h0001);
        s = cyc;
        push(s + 8, 1'b1, "R7 div4");
        push(s + 12, 1'b0, "R7 div4");
        wait (q.size() == 0);
        idle(5);

        // R7: divide by 16, L=0 H=0
        wr(2'd2, 16'h0342);
        wr(2'd0, 16'd0);
        wr(2'd3, 16'h0001);
        s = cyc;
        push(s + 16, 1'b1, "R7 div16");
        push(s + 32, 1'b0, "R7 div16");
        wait (q.size() == 0);
        idle(5);

        // R5 R6: continuous, L=2 H=1, HIGH width rewritten mid-period to 5
        wr(2'd2, 16'h0300);
        wr(2'd0, 16'd2);
        wr(2'd1, 16'd1);
        wr(2'd3, 16'h0001);
        s = cyc;
        wr(2'd1, 16'd5);
        push(s + 3, 1'b1, "R5");
        push(s + 5, 1'b0, "R6 old high width");
        push(s + 8, 1'b1, "R5");
        push(s + 14, 1'b0, "R6 new high width");
        push(s + 17, 1'b1, "R5");
        push(s + 23, 1'b0, "R6");
        wait (q.size() == 0);
        wr(2'd3, 16'h0008);
        idle(40);
        check(pulse_out == 1'b0, "R5 stop command", int'(pulse_out), 0);

        // R12: inverted polarity
        mon_en = 1'b0;
        wr(2'd2, 16'h03C0);
        idle(2);
        check(pulse_out == 1'b1, "R12 inverted idle", int'(pulse_out), 1);
        mon_en = 1'b1;
        wr(2'd0, 16'd1);
        wr(2'd1, 16'd1);
        wr(2'd3, 16'h0001);
        s = cyc;
        push(s + 2, 1'b0, "R12");
        push(s + 4, 1'b1, "R12");
        wait (q.size() == 0);
        mon_en = 1'b0;

        // R8: external rising edges, L=1 H=1
        wr(2'd2, 16'h0348);
        wr(2'd3, 16'h0001);
        ext_pulse(); idle(1);
        check(pulse_out == 1'b0, "R8 rise one edge", int'(pulse_out), 0);
        ext_pulse(); idle(1);
        check(pulse_out == 1'b1, "R8 rise two edges", int'(pulse_out), 1);
        ext_pulse(); ext_pulse(); idle(1);
        check(pulse_out == 1'b0, "R8 rise four edges", int'(pulse_out), 0);

        // R8: external falling edges
        wr(2'd2, 16'h0349);
        wr(2'd3, 16'h0001);
        ext_pulse(); idle(1);
        check(pulse_out == 1'b0, "R8 fall one edge", int'(pulse_out), 0);
        ext_pulse(); idle(1);
        check(pulse_out == 1'b1, "R8 fall two edges", int'(pulse_out), 1);

        // R8: both edges
        wr(2'd3, 16'h0008);
        wr(2'd2, 16'h034A);
        wr(2'd3, 16'h0001);
        ext_pulse(); idle(1);
        check(pulse_out == 1'b1, "R8 both one pulse", int'(pulse_out), 1);
        ext_pulse(); idle(1);
        check(pulse_out == 1'b0, "R8 both two pulses", int'(pulse_out), 0);

        // R9: falling trigger selected, rising ignored
        wr(2'd2, 16'h0360);
        wr(2'd3, 16'h0006);
        wr(2'd0, 16'd2);
        wr(2'd1, 16'd2);
        idle(1);
        prev_out = pulse_out;
        mon_en = 1'b1;
        @(negedge clk); ext_trig = 1'b1;
        idle(5);
        check(trig_irq == 1'b0, "R9 rising trigger ignored", int'(trig_irq), 0);
        check(pulse_out == 1'b0, "R9 no start on rising", int'(pulse_out), 0);
        @(negedge clk); ext_trig = 1'b0;
        @(negedge clk);
        s = cyc;
        check(trig_irq == 1'b1, "R9 falling trigger starts", int'(trig_irq), 1);
        push(s + 3, 1'b1, "R9");
        push(s + 6, 1'b0, "R9");
        wait (q.size() == 0);
        idle(3);

        // R11: underflow enable off gates the request
        wr(2'd2, 16'h0140);
        wr(2'd3, 16'h0006);
        wr(2'd0, 16'd0);
        wr(2'd1, 16'd0);
        wr(2'd3, 16'h0001);
        s = cyc;
        push(s + 1, 1'b1, "R11");
        push(s + 2, 1'b0, "R11");
        wait (q.size() == 0);
        idle(2);
        check(uf_irq == 1'b0, "R11 enable off", int'(uf_irq), 0);
        check(trig_irq == 1'b1, "R10 enable on", int'(trig_irq), 1);

        idle(5);
        finish_run();
    end
endmodule